// File: doc/BRIEF.md
# Byte-Wide General-Purpose I/O Port

This block is a general-purpose I/O port of parameterised width. It is reached through a small register bus with two addresses. One address holds a per-pin direction register. The other holds the output latch. Each pin is either driven from its latch bit or released so that its level can be sensed. A data read returns a different source for each bit. An input bit returns the synchronised pad level and an output bit returns its latch bit. Software can therefore set or clear a single bit by reading the port, changing one bit and writing the result back, and the other output bits keep their values.

A parameter mask hands selected pins to alternate functions. On those pins the pad enable and the pad level come from the owning peripheral, and the data bit of those pins reads as zero. A second parameter adds a wake-up request. The request is raised when any input pin changes from the level it had at the last data read, and the next data read clears it.

Top module: `gp_port`

## Requirements
- R1: After reset every direction bit is 1 and every latch bit is 1. No general-purpose pin is driven (`pad_oe` is 0 for those pins), `pad_out` is all ones and `wake_req` is 0.
- R2: `bus_addr` = 1 selects the direction register. Writing a 1 to a bit releases that pin (`pad_oe` = 0). Writing a 0 drives the pin with its latch bit on `pad_out`, from the cycle after the write.
- R3: A read with `bus_addr` = 0 presents on `bus_rdata`, in the cycle after `bus_rd`, the latch bit for every output-mode pin.
- R4: For every input-mode pin, the same data read returns the pad level after a two-stage synchroniser. A pad change is seen by any read issued two or more cycles after the change.
- R5: The latch keeps its value until the next data write. A value written while a pin is an input appears on the pin once the pin is switched to output.
- R6: Read-modify-write (read data, flip one bit, write back) changes only that bit of the driven outputs.
- R7: A read with `bus_addr` = 1 returns the direction register.
- R8: For pins in `ALT_MASK`, `pad_oe` and `pad_out` follow `alt_oe` and `alt_out`. Latch writes do not change them, and their data read bits are 0.
- R9: With `WAKE_EN` = 1, `wake_req` rises within three cycles of a pad change on an input-mode general-purpose pin, measured against the level captured at the last data read. It is 0 in the cycle after any data read.
- R10: Pad changes on output-mode pins or alternate-function pins never raise `wake_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | 0 = data latch, 1 = direction |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, valid the cycle after `bus_rd` |
| pad_in | input | WIDTH | Pad levels (asynchronous) |
| pad_out | output | WIDTH | Level driven on each pad |
| pad_oe | output | WIDTH | Pad drive enable, 1 = driven |
| alt_out | input | WIDTH | Alternate-function output level |
| alt_oe | input | WIDTH | Alternate-function drive enable |
| wake_req | output | 1 | Wake-up request |

## Verification
The bench builds the port with WIDTH = 8, WAKE_EN = 1 and ALT_MASK = 8'h07. Three alternate-function pins therefore sit beside five general-purpose pins. This reaches the per-bit generate split, the zeroed read bits and the wake masking for both output-mode and alternate-function pins. With the wake logic enabled, the bench can check the snapshot-and-clear behaviour after every random data read.

// File: rtl/gp_pkg.sv
package gp_pkg;
  typedef enum logic {
    ADDR_DATA = 1'b0,
    ADDR_DIR  = 1'b1
  } gp_addr_e;
endpackage

// File: rtl/gp_sync.sv
module gp_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '1;
      q        <= '1;
    end else begin
      stage1_q <= d;
      q        <= stage1_q;
    end
  end
endmodule

// File: rtl/gp_regs.sv
module gp_regs
  import gp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] lat_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '1;
      lat_q <= '1;
    end else if (wr) begin
      if (addr == ADDR_DIR) dir_q <= wdata;
      else                  lat_q <= wdata;
    end
  end

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr && addr == ADDR_DATA) |=> $stable(lat_q));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == ADDR_DIR) |=> (dir_q == $past(wdata)));
endmodule

// File: rtl/gp_wake.sv
module gp_wake #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_data,
  input  logic [WIDTH-1:0] sync_in,
  input  logic [WIDTH-1:0] watch_mask,
  output logic             wake_q
);
  logic [WIDTH-1:0] snap_q;
  logic             diff;

  assign diff = |((sync_in ^ snap_q) & watch_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '1;
      wake_q <= 1'b0;
    end else if (rd_data) begin
      snap_q <= sync_in;
      wake_q <= 1'b0;
    end else begin
      wake_q <= wake_q | diff;
    end
  end

  // R9
  wake_clr_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data |=> !wake_q);
endmodule

// File: rtl/gp_port.sv
module gp_port
  import gp_pkg::*;
#(
  parameter int               WIDTH    = 8,
  parameter bit               WAKE_EN  = 1'b1,
  parameter logic [WIDTH-1:0] ALT_MASK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  input  logic [WIDTH-1:0] alt_out,
  input  logic [WIDTH-1:0] alt_oe,
  output logic             wake_req
);
  localparam logic [WIDTH-1:0] GP_MASK = ~ALT_MASK;

  logic [WIDTH-1:0] dir_q, lat_q, sync_q, data_view;
  logic             rd_data;

  assign rd_data = bus_rd && (bus_addr == ADDR_DATA);

  gp_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .dir_q(dir_q), .lat_q(lat_q)
  );

  gp_sync #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(sync_q)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (ALT_MASK[i]) begin : g_alt
      assign pad_out[i]   = alt_out[i];
      assign pad_oe[i]    = alt_oe[i];
      assign data_view[i] = 1'b0;
    end else begin : g_gp
      assign pad_out[i]   = lat_q[i];
      assign pad_oe[i]    = ~dir_q[i];
      assign data_view[i] = dir_q[i] ? sync_q[i] : lat_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= (bus_addr == ADDR_DIR) ? dir_q : data_view;
    end
  end

  if (WAKE_EN) begin : g_wake
    gp_wake #(.WIDTH(WIDTH)) u_wake (
      .clk(clk), .rst(rst), .rd_data(rd_data), .sync_in(sync_q),
      .watch_mask(dir_q & GP_MASK), .wake_q(wake_req)
    );
  end else begin : g_nowake
    assign wake_req = 1'b0;
  end

  // R3
  rd_latch_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data |=> (((bus_rdata ^ $past(lat_q)) & ~$past(dir_q) & GP_MASK) == '0));

  // R8
  alt_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data |=> ((bus_rdata & ALT_MASK) == '0));
endmodule

// File: tb/tb_gp_port.sv
module tb_gp_port;
  localparam int         W   = 8;
  localparam logic [W-1:0] ALT = 8'h07;
  localparam logic [W-1:0] GP  = ~ALT;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0, bus_addr = 0;
  logic [W-1:0] bus_wdata = '0, bus_rdata, pad_in, pad_out, pad_oe;
  logic [W-1:0] alt_out = '0, alt_oe = '0, ext = '1;
  logic wake_req;
  int checks = 0, errors = 0;
  logic [W-1:0] dir_m, lat_m, rv;

  always #2.5 clk = ~clk;

  // pad model: driven pins show their driver, released pins show the outside level
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gp_port #(.WIDTH(W), .WAKE_EN(1'b1), .ALT_MASK(ALT)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe), .wake_req(wake_req)
  );

  function automatic logic [W-1:0] exp_read(logic [W-1:0] d, logic [W-1:0] l, logic [W-1:0] e);
    return ((d & e) | (~d & l)) & GP;
  endfunction

  function automatic logic [W-1:0] exp_oe(logic [W-1:0] d, logic [W-1:0] aoe);
    return (~d & GP) | (aoe & ALT);
  endfunction

  function automatic logic [W-1:0] exp_out(logic [W-1:0] l, logic [W-1:0] ao);
    return (l & GP) | (ao & ALT);
  endfunction

  task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic a, logic [W-1:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
    if (a) dir_m = d; else lat_m = d;
  endtask

  task automatic rd(logic a, output logic [W-1:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] e_old;
    void'($urandom(32'd1234));
    dir_m = '1; lat_m = '1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe", pad_oe & GP, '0);
    chk("R1 pad_out", pad_out & GP, GP);
    chk("R1 wake", {7'b0, wake_req}, '0);
    rd(1'b1, rv); chk("R1/R7 dir reset", rv, '1);

    // R5 write latch while input, then switch to output
    wr(1'b0, 8'hA5);
    chk("R5 released", pad_oe & GP, '0);
    wr(1'b1, 8'h00);
    chk("R2 driven oe", pad_oe, exp_oe(8'h00, alt_oe));
    chk("R5 held value", pad_out & GP, 8'hA5 & GP);
    settle();
    rd(1'b0, rv); chk("R3 read latch", rv, 8'hA5 & GP);

    // R6 read-modify-write flip bit 6
    rd(1'b0, rv);
    wr(1'b0, rv ^ 8'h40);
    chk("R6 rmw pads", pad_out & GP, (8'hA5 ^ 8'h40) & GP);

    // R4 input bits read pad through synchronizer
    wr(1'b1, 8'hF0);
    ext = 8'h5A;
    settle();
    rd(1'b0, rv); chk("R4 pad read", rv, exp_read(dir_m, lat_m, ext));

    // R8 alternate pins
    alt_oe = 8'h05; alt_out = 8'h03;
    wr(1'b0, 8'h00);
    chk("R8 alt oe", pad_oe & ALT, 8'h05);
    chk("R8 alt out", pad_out & ALT, 8'h03);

    // R9 wake on input change, cleared by read
    settle(); rd(1'b0, rv);
    chk("R9 clear", {7'b0, wake_req}, '0);
    ext = ext ^ 8'h80;
    settle();
    chk("R9 raise", {7'b0, wake_req}, 8'h01);
    rd(1'b0, rv);
    chk("R9 clear after read", {7'b0, wake_req}, '0);

    // R10 output-pin and alt-pin activity ignored
    wr(1'b0, 8'h0F);  // pins 3,2 and others low nibble: pin 3 is output (dir F0)
    ext = ext ^ 8'h07;
    alt_out = 8'h04; alt_oe = 8'h02;
    settle();
    chk("R10 no wake", {7'b0, wake_req}, '0);

    // random mix
    for (int it = 0; it < 300; it++) begin
      wr(1'b1, 8'($urandom));
      wr(1'b0, 8'($urandom));
      alt_out = 8'($urandom); alt_oe = 8'($urandom);
      ext = 8'($urandom);
      settle();
      chk("R2 oe", pad_oe, exp_oe(dir_m, alt_oe));
      chk("R8 out", pad_out, exp_out(lat_m, alt_out));
      rd(1'b0, rv); chk("R3/R4 data", rv, exp_read(dir_m, lat_m, ext));
      rd(1'b1, rv); chk("R7 dir", rv, dir_m);
      e_old = ext;
      ext = 8'($urandom);
      settle();
      chk("R9/R10 wake", {7'b0, wake_req}, {7'b0, |((ext ^ e_old) & dir_m & GP)});
      rd(1'b0, rv);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule